// File: doc/BRIEF.md
# Dual Alarm Match Unit

This block watches a live clock and calendar, given in BCD, and compares it with two programmable alarms. The first alarm has a seconds field, a minutes field, an hours field and a day-or-date field. The second alarm has minutes, hours and day-or-date, and it is only tested at the top of each minute. Each alarm byte has its own mask bit, so any field can be left out of the comparison. With masks, the alarms can fire periodically, for example once a second or once a minute.

The comparison is taken once per second-update strobe. A match sets a sticky flag, and the flag stays set until the host writes a zero to it. The flags drive two active-low, open-drain interrupt pins. Each flag is gated by its own enable, and a routing-mode bit decides which pin each alarm uses. A released pin is shown as 1, and a pin that is pulled low is shown as 0. The clock counter and the register bus are outside this block.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset both flags read 0 and both interrupt pins are released (1).
- R2: Alarm 1 matches when every unmasked field equals the live value. Its fields are seconds (bits 6:0), minutes (bits 6:0), hours and day-or-date. Bit 7 of a byte set to 1 means that field is ignored.
- R3: When all four alarm 1 bytes are masked, flag 0 is set on every update strobe.
- R4: Alarm 2 matches only when live seconds equal 00, with its minute, hour and day-or-date fields treated the same way as in alarm 1. With all three bytes masked it fires once per minute.
- R5: In a day-or-date byte, bit 6 = 1 compares bits 2:0 with the weekday. Bit 6 = 0 compares bits 5:0 with the BCD date.
- R6: The hour field compares bits 6:0 exactly with the live hour register. This includes the 12-hour select in bit 6 and the PM/tens bit in bit 5.
- R7: A match sets a flag only on a cycle where the update strobe is high. A matching time without the strobe changes nothing.
- R8: Flags are sticky. On a clear write, flag i is cleared when data bit i is 0 and is left unchanged when data bit i is 1.
- R9: If a match and a clear of the same flag occur in the same cycle, the flag ends up set.
- R10: A set flag pulls a pin low only when its enable bit is 1 (enable bit 0 for alarm 1, bit 1 for alarm 2).
- R11: With route_sel = 1, alarm 1 drives pin A and alarm 2 drives pin B. With route_sel = 0, pin A stays released and pin B is the OR of both enabled flags.
- R12: A flag is updated in the clock edge that samples the strobe. It is visible on `flags` and the pins from that edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle second-update strobe |
| tm_sec | input | 7 | Live seconds, BCD |
| tm_min | input | 7 | Live minutes, BCD |
| tm_hour | input | 7 | Live hour register (bit 6 12h select, bit 5 PM/tens) |
| tm_wday | input | 3 | Live weekday 1..7 |
| tm_date | input | 6 | Live date, BCD |
| a1_sec_reg | input | 8 | Alarm 1 seconds byte (bit 7 mask) |
| a1_min_reg | input | 8 | Alarm 1 minutes byte (bit 7 mask) |
| a1_hour_reg | input | 8 | Alarm 1 hour byte (bit 7 mask) |
| a1_day_reg | input | 8 | Alarm 1 day-or-date byte (bit 7 mask, bit 6 weekday select) |
| a2_min_reg | input | 8 | Alarm 2 minutes byte |
| a2_hour_reg | input | 8 | Alarm 2 hour byte |
| a2_day_reg | input | 8 | Alarm 2 day-or-date byte |
| irq_en | input | 2 | Interrupt enables, bit 0 alarm 1, bit 1 alarm 2 |
| route_sel | input | 1 | 1: one alarm per pin; 0: both alarms on pin B |
| clr_we | input | 1 | Flag clear write strobe |
| clr_data | input | 2 | Clear write data, 0 clears the flag |
| flags | output | 2 | Sticky flags, bit 0 alarm 1, bit 1 alarm 2 |
| irq_a_n | output | 1 | Interrupt pin A, active low, 1 = released |
| irq_b_n | output | 1 | Interrupt pin B, active low, 1 = released |

## Verification
Alarm 1 seconds are swept over all 60 BCD values while alarm 2 is fully masked. This separates a seconds compare from the minute-boundary gating of alarm 2. The hour compare is swept over all 128 codes of the 7-bit hour register against a 12-hour PM alarm. Any compare that drops the mode or PM bit would then match extra codes. The weekday and date modes are swept against values that agree in one encoding but not in the other. The pins are tried under all routing and enable settings, with each single-flag pattern and with both flags set, which separates per-pin routing from the shared OR.

// File: rtl/alarm_match_unit_pkg.sv
package alarm_match_unit_pkg;
    localparam int NUM_ALARMS = 2;
    localparam int BCD_W      = 7;
    localparam int WDAY_W     = 3;
    localparam int DATE_W     = 6;
    localparam int REG_W      = 8;
    localparam int MASK_BIT   = REG_W - 1;
    localparam int DAYSEL_BIT = REG_W - 2;

    typedef struct packed {
        logic [BCD_W-1:0]  sec;
        logic [BCD_W-1:0]  min;
        logic [BCD_W-1:0]  hour;
        logic [WDAY_W-1:0] wday;
        logic [DATE_W-1:0] date;
    } live_time_t;

    typedef struct packed {
        logic [REG_W-1:0] sec;
        logic [REG_W-1:0] min;
        logic [REG_W-1:0] hour;
        logic [REG_W-1:0] day;
    } alarm_bytes_t;

    typedef struct packed {
        logic [NUM_ALARMS-1:0] flag;
    } amu_state_t;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp
    import alarm_match_unit_pkg::*;
(
    input  live_time_t   now,
    input  alarm_bytes_t regs,
    output logic         hit
);
    logic sec_ok, min_ok, hour_ok, day_ok, day_val_ok;

    always_comb begin
        sec_ok  = regs.sec[MASK_BIT]  | (regs.sec[BCD_W-1:0]  == now.sec);
        min_ok  = regs.min[MASK_BIT]  | (regs.min[BCD_W-1:0]  == now.min);
        hour_ok = regs.hour[MASK_BIT] | (regs.hour[BCD_W-1:0] == now.hour);
        if (regs.day[DAYSEL_BIT]) begin
            day_val_ok = (regs.day[WDAY_W-1:0] == now.wday);
        end else begin
            day_val_ok = (regs.day[DATE_W-1:0] == now.date);
        end
        day_ok = regs.day[MASK_BIT] | day_val_ok;
        hit    = sec_ok & min_ok & hour_ok & day_ok;
    end
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
    import alarm_match_unit_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic [6:0]  tm_sec,
    input  logic [6:0]  tm_min,
    input  logic [6:0]  tm_hour,
    input  logic [2:0]  tm_wday,
    input  logic [5:0]  tm_date,
    input  logic [7:0]  a1_sec_reg,
    input  logic [7:0]  a1_min_reg,
    input  logic [7:0]  a1_hour_reg,
    input  logic [7:0]  a1_day_reg,
    input  logic [7:0]  a2_min_reg,
    input  logic [7:0]  a2_hour_reg,
    input  logic [7:0]  a2_day_reg,
    input  logic [1:0]  irq_en,
    input  logic        route_sel,
    input  logic        clr_we,
    input  logic [1:0]  clr_data,
    output logic [1:0]  flags,
    output logic        irq_a_n,
    output logic        irq_b_n
);
    live_time_t            now;
    alarm_bytes_t          regs [NUM_ALARMS];
    logic [NUM_ALARMS-1:0] hit;
    logic [NUM_ALARMS-1:0] req;
    amu_state_t            st_d, st_q;

    // The second alarm has no seconds byte. It is given a fixed unmasked
    // seconds value of 00, so it fires only at the minute boundary.
    always_comb begin
        now.sec  = tm_sec;
        now.min  = tm_min;
        now.hour = tm_hour;
        now.wday = tm_wday;
        now.date = tm_date;
        regs[0]  = '{sec: a1_sec_reg, min: a1_min_reg, hour: a1_hour_reg, day: a1_day_reg};
        regs[1]  = '{sec: '0,         min: a2_min_reg, hour: a2_hour_reg, day: a2_day_reg};
    end

    for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_cmp
        alarm_field_cmp u_cmp (
            .now  (now),
            .regs (regs[i]),
            .hit  (hit[i])
        );
    end

    // Next state: the clear write applies first and a strobed match is
    // applied after it, so a match wins over a clear in the same cycle.
    always_comb begin
        st_d = st_q;
        if (clr_we) begin
            st_d.flag = st_d.flag & clr_data;
        end
        if (tick) begin
            st_d.flag = st_d.flag | hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        req   = st_q.flag & irq_en;
        flags = st_q.flag;
        if (route_sel) begin
            irq_a_n = ~req[0];
            irq_b_n = ~req[1];
        end else begin
            irq_a_n = 1'b1;
            irq_b_n = ~(|req);
        end
    end
endmodule

// File: rtl/alarm_match_unit_chk.sv
module alarm_match_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic [6:0] tm_sec,
    input logic [7:0] a1_sec_reg,
    input logic [7:0] a1_min_reg,
    input logic [7:0] a1_hour_reg,
    input logic [7:0] a1_day_reg,
    input logic [1:0] irq_en,
    input logic       route_sel,
    input logic       clr_we,
    input logic [1:0] clr_data,
    input logic [1:0] flags,
    input logic       irq_a_n,
    input logic       irq_b_n
);
    p_no_set_without_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ((flags & ~$past(flags)) == 2'b00));

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr_we) |=> (flags == $past(flags)));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !tick) |=> ((flags & ~$past(clr_data)) == 2'b00));

    p_a2_minute_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr_we && tm_sec != 7'h00) |=> (flags[1] == $past(flags[1])));

    p_every_second_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && a1_sec_reg[7] && a1_min_reg[7] && a1_hour_reg[7] && a1_day_reg[7])
        |=> flags[0]);

    p_pin_a_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !route_sel |-> irq_a_n);

    p_pin_a_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (route_sel && flags[0] && irq_en[0]) |-> !irq_a_n);

    p_no_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 2'b00) |-> (irq_a_n && irq_b_n));
endmodule

bind alarm_match_unit alarm_match_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .tm_sec      (tm_sec),
    .a1_sec_reg  (a1_sec_reg),
    .a1_min_reg  (a1_min_reg),
    .a1_hour_reg (a1_hour_reg),
    .a1_day_reg  (a1_day_reg),
    .irq_en      (irq_en),
    .route_sel   (route_sel),
    .clr_we      (clr_we),
    .clr_data    (clr_data),
    .flags       (flags),
    .irq_a_n     (irq_a_n),
    .irq_b_n     (irq_b_n)
);

// File: tb/alarm_match_unit_test.sv
module alarm_match_unit_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [6:0] tm_sec = '0, tm_min = '0, tm_hour = '0;
    logic [2:0] tm_wday = 3'd1;
    logic [5:0] tm_date = 6'h01;
    logic [7:0] a1_sec_reg = 8'h80, a1_min_reg = 8'h80, a1_hour_reg = 8'h80, a1_day_reg = 8'h80;
    logic [7:0] a2_min_reg = 8'h80, a2_hour_reg = 8'h80, a2_day_reg = 8'h80;
    logic [1:0] irq_en = 2'b00;
    logic       route_sel = 1'b1;
    logic       clr_we = 1'b0;
    logic [1:0] clr_data = 2'b11;
    logic [1:0] flags;
    logic       irq_a_n, irq_b_n;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alarm_match_unit uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour),
        .tm_wday(tm_wday), .tm_date(tm_date),
        .a1_sec_reg(a1_sec_reg), .a1_min_reg(a1_min_reg),
        .a1_hour_reg(a1_hour_reg), .a1_day_reg(a1_day_reg),
        .a2_min_reg(a2_min_reg), .a2_hour_reg(a2_hour_reg), .a2_day_reg(a2_day_reg),
        .irq_en(irq_en), .route_sel(route_sel),
        .clr_we(clr_we), .clr_data(clr_data),
        .flags(flags), .irq_a_n(irq_a_n), .irq_b_n(irq_b_n)
    );

    function automatic logic [6:0] bcd(input int v);
        return 7'(((v / 10) << 4) | (v % 10));
    endfunction

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One strobe: drive at a falling edge, the flag updates at the next
    // rising edge, and the result is sampled at the falling edge after it.
    task automatic strobe(input logic with_clear, input logic [1:0] cd);
        @(negedge clk);
        tick = 1'b1; clr_we = with_clear; clr_data = cd;
        @(negedge clk);
        tick = 1'b0; clr_we = 1'b0; clr_data = 2'b11;
    endtask

    task automatic clear_flags(input logic [1:0] cd);
        @(negedge clk);
        clr_we = 1'b1; clr_data = cd;
        @(negedge clk);
        clr_we = 1'b0; clr_data = 2'b11;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(flags, 0, "R1 flags");
        check({irq_a_n, irq_b_n}, 2'b11, "R1 pins");
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R4: sweep alarm 1 seconds over 0..59, alarm 2 fully masked
        a1_sec_reg = 8'h25;
        tm_min = bcd(7);
        for (int s = 0; s < 60; s++) begin
            clear_flags(2'b00);
            tm_sec = bcd(s);
            strobe(1'b0, 2'b11);
            check(flags[0], (s == 25), $sformatf("R2 sec=%0d", s));
            check(flags[1], (s == 0),  $sformatf("R4 sec=%0d", s));
        end

        // R2: minute field unmasked in alarm 1
        a1_sec_reg = 8'h80; a1_min_reg = 8'h42;
        for (int m = 0; m < 60; m++) begin
            clear_flags(2'b00);
            tm_sec = bcd(11); tm_min = bcd(m);
            strobe(1'b0, 2'b11);
            check(flags[0], (m == 42), $sformatf("R2 min=%0d", m));
        end
        a1_min_reg = 8'h80;

        // R4: alarm 2 minute match, only at seconds 00
        a2_min_reg = 8'h30; tm_min = bcd(30);
        for (int s = 0; s < 3; s++) begin
            clear_flags(2'b00);
            tm_sec = bcd(s);
            strobe(1'b0, 2'b11);
            check(flags[1], (s == 0), $sformatf("R4 min30 sec=%0d", s));
        end
        clear_flags(2'b00);
        tm_sec = bcd(0); tm_min = bcd(31);
        strobe(1'b0, 2'b11);
        check(flags[1], 0, "R4 min31");
        a2_min_reg = 8'h80;

        // R3: every strobe sets flag 0 with all alarm 1 bytes masked
        for (int k = 0; k < 6; k++) begin
            clear_flags(2'b00);
            tm_sec = bcd(k * 9 + 1); tm_min = bcd(k * 7); tm_date = bcd(k + 3);
            strobe(1'b0, 2'b11);
            check(flags[0], 1, $sformatf("R3 step=%0d", k));
        end

        // R5: weekday mode; date held equal to the alarm's low bits
        a1_day_reg = 8'h43;
        tm_date = bcd(3);
        for (int w = 1; w <= 7; w++) begin
            clear_flags(2'b00);
            tm_wday = 3'(w);
            strobe(1'b0, 2'b11);
            check(flags[0], (w == 3), $sformatf("R5 wday=%0d", w));
        end
        // R5: date mode; weekday held at 5 throughout
        a1_day_reg = 8'h15;
        tm_wday = 3'd5;
        for (int d = 1; d <= 31; d++) begin
            clear_flags(2'b00);
            tm_date = bcd(d);
            strobe(1'b0, 2'b11);
            check(flags[0], (d == 15), $sformatf("R5 date=%0d", d));
        end
        a1_day_reg = 8'h80;

        // R6: all 128 hour codes against 12-hour PM 5 (0x65)
        a1_hour_reg = 8'h65;
        for (int h = 0; h < 128; h++) begin
            clear_flags(2'b00);
            tm_hour = 7'(h);
            strobe(1'b0, 2'b11);
            check(flags[0], (h == 'h65), $sformatf("R6 hour=%0h", h));
        end
        a1_hour_reg = 8'h80;

        // R7: matching time without the strobe sets nothing
        clear_flags(2'b00);
        tm_sec = bcd(0);
        repeat (5) @(negedge clk);
        check(flags, 0, "R7 no strobe");

        // R8: sticky flags and selective clear
        strobe(1'b0, 2'b11);
        repeat (4) @(negedge clk);
        check(flags, 2'b11, "R8 sticky");
        clear_flags(2'b10);
        check(flags, 2'b10, "R8 clear bit0");
        clear_flags(2'b11);
        check(flags, 2'b10, "R8 write ones");
        clear_flags(2'b01);
        check(flags, 2'b00, "R8 clear bit1");

        // R9: match and clear in the same cycle
        strobe(1'b1, 2'b00);
        check(flags, 2'b11, "R9 set wins");

        // R10/R11/R12: pins over every flag pattern, route and enable
        for (int fp = 1; fp <= 3; fp++) begin
            strobe(1'b0, 2'b11);
            clear_flags(2'(fp));
            check(flags, fp, "R12 pattern");
            for (int r = 0; r < 2; r++) begin
                for (int en = 0; en < 4; en++) begin
                    int q0, q1, ea, eb;
                    route_sel = r[0]; irq_en = 2'(en);
                    @(negedge clk);
                    q0 = fp & en & 1;
                    q1 = (fp & en & 2) >> 1;
                    ea = (r == 1) ? (q0 == 0) : 1;
                    eb = (r == 1) ? (q1 == 0) : ((q0 | q1) == 0);
                    check(irq_a_n, ea, $sformatf("R11 pinA f=%0d r=%0d en=%0d", fp, r, en));
                    check(irq_b_n, eb, $sformatf("R10 pinB f=%0d r=%0d en=%0d", fp, r, en));
                end
            end
        end

        finish_run();
    end
endmodule